// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block sits on the host side of a serial-readout line sensor. It makes the sensor's start pulse and its clock from the system clock. It also issues one converter sample strobe per pixel, tagged with the pixel's position in the line. The sensor clock comes from a programmable half-period divider. The divider setting is clamped so that the clock pulses never fall below the minimum width the sensor accepts. The clamp also keeps a full clock period longer than the analog settling delay that comes before each sample.

A frame begins with the start pulse, which is high across exactly one rising clock edge. One pixel is presented after each following edge. One more edge after the last pixel closes the frame. The interval between two capture edges is the sensor's exposure time. It is programmed in sensor clock periods and is never allowed to drop below the length of a frame. A request that is too short is stretched, and a sticky warning records it. In single-shot mode, one start request runs one exposure period. In continuous mode, frames follow each other until the mode input is cleared. The mode input is sampled at the end of each period.

Top module: `linescan_seq`

## Requirements
- R1: After reset, and whenever busy is low, the start pulse, sensor clock, sample strobe, frame flags and busy are all 0, and the warning flag is 0 after reset.
- R2: A start request accepted while idle raises the start pulse exactly one sensor half-period before the rising clock edge that captures it. The pulse changes only while the sensor clock is low, and it is high on exactly one rising edge per frame.
- R3: Every sensor clock high and low phase lasts H system cycles. H is the divider input clamped into [max(HALF_MIN, SETTLE_CYC/2+1), HALF_MAX]. With the defaults this range is [6, 5000].
- R4: For edges 1 to NUM_PIXELS after the capture edge (the capture edge is edge 1), one single-cycle sample strobe is raised exactly SETTLE_CYC system cycles after the sensor clock goes high. The strobe carries the pixel index (edge number minus 1), which counts 0, 1, ... NUM_PIXELS-1 in order.
- R5: The frame-start flag is a one-cycle pulse in the first cycle the sensor clock is high after the capture edge. The frame-done flag is a one-cycle pulse in the first high cycle after edge NUM_PIXELS+1. The two flags never assert together.
- R6: The exposure period P in sensor clock periods is the period input if that is at least NUM_PIXELS+1; otherwise P is NUM_PIXELS+1 and the warning flag is set. The warning stays set until reset.
- R7: In single-shot mode, busy stays high for exactly 2·H·P system cycles from the cycle after the accepted start request, and one frame is captured.
- R8: A start request that arrives while busy is high has no effect.
- R9: At the falling sensor clock edge that ends edge P, the continuous-mode input is sampled. If it is 1, the next capture follows half a period later, so the capture-to-capture interval is exactly P sensor periods. If it is 0, the sequencer goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_div_i | input | DIV_W | Requested sensor clock half-period in system cycles |
| period_i | input | PER_W | Requested exposure period in sensor clock periods |
| start_i | input | 1 | Start request, sampled while idle |
| cont_i | input | 1 | Continuous mode, sampled at each period end |
| sen_si_o | output | 1 | Start pulse to the sensor |
| sen_clk_o | output | 1 | Clock to the sensor |
| adc_strobe_o | output | 1 | One-cycle converter sample strobe |
| pix_idx_o | output | IDX_W | Pixel index, valid with the strobe |
| frame_start_o | output | 1 | Capture edge flag |
| frame_done_o | output | 1 | Closing edge flag |
| busy_o | output | 1 | Exposure period in progress |
| period_warn_o | output | 1 | Sticky short-period warning |

## Verification
Two events can land in the same system cycle, and the bench provokes both. The first is the clearing of continuous mode against the end-of-period decision. The bench counts system cycles from the observed frame-start flag and drops the mode input either just before or just after the decision edge. It then judges by whether exactly one or exactly two captures follow, and by the measured capture-to-capture interval. The second is a start request raised in the very cycle that frame-done is seen. For that case the bench checks that the capture count and the busy duration are unchanged.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lss_cfg.sv
module lss_cfg #(
   parameter int DIV_W      = 16,
   parameter int PER_W      = 20,
   parameter int HALF_FLOOR = 6,
   parameter int HALF_MAX   = 5000,
   parameter int PER_MIN    = 513
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [DIV_W-1:0] half_div_i,
   input  logic [PER_W-1:0] period_i,
   output logic [DIV_W-1:0] half_o,
   output logic [PER_W-1:0] per_o,
   output logic             warn_o
);

   localparam logic [DIV_W-1:0] HLO = DIV_W'(HALF_FLOOR);
   localparam logic [DIV_W-1:0] HHI = DIV_W'(HALF_MAX);
   localparam logic [PER_W-1:0] PLO = PER_W'(PER_MIN);

   logic [DIV_W-1:0] half_clamp;
   logic [PER_W-1:0] per_clamp;
   logic             per_short;

   always_comb begin
      if (half_div_i < HLO)      half_clamp = HLO;
      else if (half_div_i > HHI) half_clamp = HHI;
      else                       half_clamp = half_div_i;
   end

   assign per_short = (period_i < PLO);
   assign per_clamp = per_short ? PLO : period_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         half_o <= HLO;
         per_o  <= PLO;
         warn_o <= 1'b0;
      end else if (load_i) begin
         half_o <= half_clamp;
         per_o  <= per_clamp;
         if (per_short) warn_o <= 1'b1;
      end
   end

endmodule

// File: rtl/lss_clkgen.sv
module lss_clkgen #(
   parameter int DIV_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] half_i,
   output logic             sclk_o,
   output logic             rise_o,
   output logic             fall_o
);

   logic [DIV_W-1:0] cnt_q;
   logic             sclk_q;
   logic             tick;

   // tick marks the cycle whose closing edge flips the sensor clock
   assign tick   = run_i && (cnt_q == half_i - DIV_W'(1));
   assign rise_o = tick && !sclk_q;
   assign fall_o = tick && sclk_q;
   assign sclk_o = sclk_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (tick) begin
         cnt_q  <= '0;
         sclk_q <= !sclk_q;
      end else begin
         cnt_q  <= cnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/lss_frame_ctrl.sv
module lss_frame_ctrl
   import lss_pkg::*;
#(
   parameter int NUM_PIXELS = 512,
   parameter int PER_W      = 20,
   parameter int IDX_W      = 9
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             cont_i,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic [PER_W-1:0] per_i,
   output logic             busy_o,
   output logic             si_o,
   output logic             load_o,
   output logic             fstart_o,
   output logic             fdone_o,
   output logic             pix_load_o,
   output logic [IDX_W-1:0] pix_num_o
);

   localparam logic [PER_W-1:0] DONE_EDGE = PER_W'(NUM_PIXELS + 1);
   localparam logic [PER_W-1:0] LAST_PIX  = PER_W'(NUM_PIXELS);

   seq_state_e       st_q;
   logic             si_q;
   logic             fs_q;
   logic             fd_q;
   logic [PER_W-1:0] edge_q;
   logic [PER_W-1:0] edge_nx;
   logic             at_end;
   logic             go_on;
   logic             running;

   assign running    = (st_q == SEQ_RUN);
   // a rising edge that sees the start pulse high restarts the edge count
   assign edge_nx    = si_q ? PER_W'(1) : edge_q + PER_W'(1);
   assign at_end     = running && fall_i && (edge_q == per_i);
   assign go_on      = at_end && cont_i;
   assign load_o     = (!running && start_i) || go_on;
   assign pix_load_o = running && rise_i && (edge_nx <= LAST_PIX);
   assign pix_num_o  = IDX_W'(edge_nx - PER_W'(1));

   assign busy_o   = running;
   assign si_o     = si_q;
   assign fstart_o = fs_q;
   assign fdone_o  = fd_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= SEQ_IDLE;
         si_q   <= 1'b0;
         fs_q   <= 1'b0;
         fd_q   <= 1'b0;
         edge_q <= '0;
      end else begin
         fs_q <= 1'b0;
         fd_q <= 1'b0;
         if (!running) begin
            if (start_i) begin
               st_q   <= SEQ_RUN;
               si_q   <= 1'b1;
               edge_q <= '0;
            end
         end else begin
            if (rise_i) begin
               edge_q <= edge_nx;
               fs_q   <= si_q;
               fd_q   <= (edge_nx == DONE_EDGE);
            end
            if (fall_i) begin
               if (edge_q == PER_W'(1)) si_q <= 1'b0;
               if (at_end) begin
                  if (cont_i) si_q <= 1'b1;
                  else        st_q <= SEQ_IDLE;
               end
            end
         end
      end
   end

endmodule

// File: rtl/lss_strobe_gen.sv
module lss_strobe_gen #(
   parameter int IDX_W      = 9,
   parameter int SETTLE_CYC = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pix_load_i,
   input  logic [IDX_W-1:0] pix_num_i,
   output logic             stb_o,
   output logic [IDX_W-1:0] idx_o
);

   logic             stb_q;
   logic             pend_q;
   logic [IDX_W-1:0] idx_pend_q;
   logic [IDX_W-1:0] idx_q;
   logic             fire;

   assign stb_o = stb_q;
   assign idx_o = idx_q;

   generate
      if (SETTLE_CYC == 1) begin : g_direct
         assign fire = pend_q;
      end else begin : g_count
         localparam int CW = $clog2(SETTLE_CYC + 1);
         logic [CW-1:0] dly_q;
         assign fire = pend_q && (dly_q == CW'(1));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)         dly_q <= '0;
            else if (pix_load_i) dly_q <= CW'(SETTLE_CYC);
            else if (pend_q)     dly_q <= dly_q - CW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stb_q      <= 1'b0;
         pend_q     <= 1'b0;
         idx_pend_q <= '0;
         idx_q      <= '0;
      end else begin
         stb_q <= 1'b0;
         if (pix_load_i) begin
            pend_q     <= 1'b1;
            idx_pend_q <= pix_num_i;
         end else if (fire) begin
            pend_q <= 1'b0;
            stb_q  <= 1'b1;
            idx_q  <= idx_pend_q;
         end
      end
   end

endmodule

// File: rtl/linescan_seq.sv
module linescan_seq
   import lss_pkg::*;
#(
   parameter int NUM_PIXELS = 512,
   parameter int DIV_W      = 16,
   parameter int PER_W      = 20,
   parameter int HALF_MIN   = 3,
   parameter int HALF_MAX   = 5000,
   parameter int SETTLE_CYC = 10,
   localparam int IDX_W     = $clog2(NUM_PIXELS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] half_div_i,
   input  logic [PER_W-1:0] period_i,
   input  logic             start_i,
   input  logic             cont_i,
   output logic             sen_si_o,
   output logic             sen_clk_o,
   output logic             adc_strobe_o,
   output logic [IDX_W-1:0] pix_idx_o,
   output logic             frame_start_o,
   output logic             frame_done_o,
   output logic             busy_o,
   output logic             period_warn_o
);

   localparam int HALF_FLOOR = max2(HALF_MIN, SETTLE_CYC / 2 + 1);
   localparam int PER_MIN    = NUM_PIXELS + 1;

   generate
      if (NUM_PIXELS < 2) begin : g_err_np
         $error("NUM_PIXELS must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_err_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (HALF_MAX < HALF_FLOOR) begin : g_err_half
         $error("HALF_MAX is below the derived half-period floor");
      end
      if (PER_W > 30 || PER_MIN >= (1 << PER_W)) begin : g_err_per
         $error("PER_W cannot hold NUM_PIXELS+1");
      end
      if (DIV_W > 30 || HALF_MAX >= (1 << DIV_W)) begin : g_err_div
         $error("DIV_W cannot hold HALF_MAX");
      end
   endgenerate

   logic [DIV_W-1:0] half_eff;
   logic [PER_W-1:0] per_eff;
   logic             load;
   logic             run;
   logic             rise_ev;
   logic             fall_ev;
   logic             pix_load;
   logic [IDX_W-1:0] pix_num;

   lss_cfg #(
      .DIV_W(DIV_W), .PER_W(PER_W), .HALF_FLOOR(HALF_FLOOR),
      .HALF_MAX(HALF_MAX), .PER_MIN(PER_MIN)
   ) u_cfg (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
      .half_div_i(half_div_i), .period_i(period_i),
      .half_o(half_eff), .per_o(per_eff), .warn_o(period_warn_o)
   );

   lss_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .half_i(half_eff),
      .sclk_o(sen_clk_o), .rise_o(rise_ev), .fall_o(fall_ev)
   );

   lss_frame_ctrl #(.NUM_PIXELS(NUM_PIXELS), .PER_W(PER_W), .IDX_W(IDX_W)) u_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cont_i(cont_i),
      .rise_i(rise_ev), .fall_i(fall_ev), .per_i(per_eff),
      .busy_o(run), .si_o(sen_si_o), .load_o(load),
      .fstart_o(frame_start_o), .fdone_o(frame_done_o),
      .pix_load_o(pix_load), .pix_num_o(pix_num)
   );

   lss_strobe_gen #(.IDX_W(IDX_W), .SETTLE_CYC(SETTLE_CYC)) u_stb (
      .clk_i(clk_i), .rst_ni(rst_ni), .pix_load_i(pix_load), .pix_num_i(pix_num),
      .stb_o(adc_strobe_o), .idx_o(pix_idx_o)
   );

   assign busy_o = run;

endmodule

// File: rtl/linescan_seq_chk.sv
module linescan_seq_chk #(
   parameter int HALF_MIN   = 3,
   parameter int SETTLE_CYC = 10
) (
   input logic clk_i,
   input logic rst_ni,
   input logic sen_si_i,
   input logic sen_clk_i,
   input logic adc_strobe_i,
   input logic frame_start_i,
   input logic frame_done_i,
   input logic busy_i,
   input logic warn_i
);

   localparam int FLOOR = (HALF_MIN > SETTLE_CYC / 2 + 1) ? HALF_MIN : SETTLE_CYC / 2 + 1;

   logic        clk_d;
   logic        cap_last;
   logic [31:0] lvl_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         clk_d    <= 1'b0;
         cap_last <= 1'b0;
         lvl_cnt  <= '1;
      end else begin
         clk_d <= sen_clk_i;
         if (sen_clk_i && !clk_d) cap_last <= sen_si_i;
         if (sen_clk_i != clk_d)    lvl_cnt <= 32'd1;
         else if (lvl_cnt != '1)    lvl_cnt <= lvl_cnt + 32'd1;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_i |-> (!sen_clk_i && !sen_si_i && !frame_start_i && !frame_done_i)); // R1
   AST_SI_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sen_clk_i |-> $stable(sen_si_i)); // R2
   AST_SI_SINGLE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sen_clk_i && !clk_d && sen_si_i) |-> !cap_last); // R2
   AST_CLK_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && (sen_clk_i != clk_d)) |-> (lvl_cnt >= 32'(FLOOR))); // R3
   AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adc_strobe_i |=> !adc_strobe_i); // R4
   AST_STROBE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adc_strobe_i |-> busy_i); // R4
   AST_START_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(frame_start_i && frame_done_i)); // R5
   AST_START_ON_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_start_i |-> (sen_clk_i && sen_si_i)); // R5
   AST_WARN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warn_i |=> warn_i); // R6

endmodule

bind linescan_seq linescan_seq_chk #(.HALF_MIN(HALF_MIN), .SETTLE_CYC(SETTLE_CYC)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .sen_si_i(sen_si_o), .sen_clk_i(sen_clk_o),
   .adc_strobe_i(adc_strobe_o), .frame_start_i(frame_start_o),
   .frame_done_i(frame_done_o), .busy_i(busy_o), .warn_i(period_warn_o)
);

// File: tb/linescan_seq_tb.sv
`timescale 1ns/1ps
module linescan_seq_tb;

   localparam int NPIX   = 512;
   localparam int SETTLE = 10;
   localparam int HMAX   = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] half_div = 16'd6;
   logic [19:0] period = 20'd513;
   logic        start = 1'b0;
   logic        cont = 1'b0;
   logic        si, sclk, stb, fs, fd, busy, warn;
   logic [8:0]  idx;

   always #10 clk = ~clk;

   linescan_seq #(.HALF_MAX(HMAX)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .half_div_i(half_div), .period_i(period),
      .start_i(start), .cont_i(cont), .sen_si_o(si), .sen_clk_o(sclk),
      .adc_strobe_o(stb), .pix_idx_o(idx), .frame_start_o(fs), .frame_done_o(fd),
      .busy_o(busy), .period_warn_o(warn)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor state
   longint cyc = 0;
   int     h_cur = 6;
   int     captures, strobes, done_seen, busy_cyc;
   int     err_fs, err_fd, err_idx, err_settle, err_half, err_setup;
   longint last_rise, last_tr, si_rise, prev_cap, interval;
   bit     tr_valid, cap_valid, prev_sclk, prev_si;
   int     edge_no;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic clear_stats();
      captures = 0; strobes = 0; done_seen = 0; busy_cyc = 0;
      err_fs = 0; err_fd = 0; err_idx = 0; err_settle = 0; err_half = 0; err_setup = 0;
      interval = 0; edge_no = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) busy_cyc++;
         if (si && !prev_si) si_rise = cyc;
         if (sclk != prev_sclk) begin
            if (busy && tr_valid && (cyc - last_tr) != h_cur) err_half++;
            last_tr = cyc;
            tr_valid = busy;
         end
         if (sclk && !prev_sclk) begin
            last_rise = cyc;
            if (si) begin
               captures++;
               if ((cyc - si_rise) != h_cur) err_setup++;
               if (cap_valid) interval = cyc - prev_cap;
               prev_cap = cyc; cap_valid = 1'b1;
               strobes = 0; edge_no = 1;
               if (!fs) err_fs++;
            end else begin
               edge_no++;
               if (fs) err_fs++;
            end
            if (fd != (edge_no == NPIX + 1)) err_fd++;
            if (edge_no == NPIX + 1) done_seen++;
         end else if (fs || fd) begin
            err_fs++;
         end
         if (stb) begin
            if (idx != strobes[8:0]) err_idx++;
            if ((cyc - last_rise) != SETTLE) err_settle++;
            strobes++;
         end
         if (!busy) begin tr_valid = 1'b0; cap_valid = 1'b0; end
      end
      prev_sclk = sclk;
      prev_si = si;
   end

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic common_checks(input string tag);
      check({tag, " R2 capture setup"}, err_setup, 0);
      check({tag, " R3 half period"}, err_half, 0);
      check({tag, " R4 strobe index order"}, err_idx, 0);
      check({tag, " R4 strobe settle delay"}, err_settle, 0);
      check({tag, " R4 strobes in last frame"}, strobes, NPIX);
      check({tag, " R5 frame_start placement"}, err_fs, 0);
      check({tag, " R5 frame_done placement"}, err_fd, 0);
      check({tag, " R5 done count"}, done_seen, captures);
   endtask

   task automatic t_reset();
      check("R1 si after reset", si, 0);
      check("R1 sclk after reset", sclk, 0);
      check("R1 strobe after reset", stb, 0);
      check("R1 busy after reset", busy, 0);
      check("R1 frame flags after reset", fs | fd, 0);
      check("R1 warn after reset", warn, 0);
   endtask

   // single-shot frame; poke raises start in the frame_done cycle (R8)
   task automatic t_single(input int div, input int per, input int h_exp,
                           input int p_exp, input bit poke, input string tag);
      @(posedge clk);
      half_div = 16'(div); period = 20'(per); cont = 1'b0; h_cur = h_exp;
      clear_stats();
      pulse_start();
      while (busy) begin
         @(negedge clk);
         start = poke && fd;
      end
      start = 1'b0;
      repeat (4) @(negedge clk);
      check({tag, " R7 captures"}, captures, 1);
      check({tag, " R7 busy cycles"}, busy_cyc, 2 * h_exp * p_exp);
      check({tag, " R1 idle clock low"}, sclk, 0);
      common_checks(tag);
   endtask

   // continuous run; mode dropped one cycle before (late=0) or at (late=1) the decision
   task automatic t_cont(input bit late, input string tag);
      int d;
      @(posedge clk);
      half_div = 16'd6; period = 20'd520; cont = 1'b1; h_cur = 6;
      clear_stats();
      pulse_start();
      do @(negedge clk); while (!fs);
      d = 2 * 6 * 520 - 6;
      repeat (late ? d : d - 1) @(negedge clk);
      cont = 1'b0;
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check({tag, " R9 captures"}, captures, late ? 2 : 1);
      check({tag, " R9 busy cycles"}, busy_cyc, (late ? 2 : 1) * 2 * 6 * 520);
      if (late) check({tag, " R9 capture interval"}, interval, 2 * 6 * 520);
      common_checks(tag);
   endtask

   initial begin
      clear_stats();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_single(6, 513, 6, 513, 1'b0, "nominal");
      check("R6 no warn for legal period", warn, 0);
      t_single(2, 513, 6, 513, 1'b0, "clamp_low R3");
      t_single(20, 513, HMAX, 513, 1'b0, "clamp_high R3");
      t_single(8, 600, 8, 600, 1'b0, "long_period");
      t_single(6, 513, 6, 513, 1'b1, "start_on_done R8");
      check("R6 warn still clear", warn, 0);
      t_single(6, 100, 6, 513, 1'b0, "short_period R6");
      check("R6 warn set by short period", warn, 1);
      t_cont(1'b0, "cont_drop_early");
      t_cont(1'b1, "cont_drop_late");
      check("R6 warn sticky", warn, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule